// File: doc/BRIEF.md
# Precision-Trading Fault-Tolerant Single-Precision Multiplier

This block multiplies two 32-bit single-precision floating-point numbers and lets the surrounding system exchange accuracy for protection at run time. With the mode input set to full precision, the whole 24-bit significands, hidden bit included, are multiplied and the product fraction is truncated to 23 bits. With either protected mode selected, only the top fraction bits of each operand are kept. The freed multiplier capacity then carries extra copies of the shorter significand product, which are checked against one another.

In the checking mode, 13 fraction bits per operand survive. Two copies of the 14x14 significand product are compared, and any difference raises the error flag. In the repairing mode, 11 fraction bits survive. Three copies of the 12x12 product feed a bitwise two-of-three vote, so one bad copy is masked while the flag still reports that the copies disagreed. The sign, the biased exponent sum, the normalisation by one place, saturation to infinity and flush to zero are shared by all modes.

The result is registered, so it appears one cycle after the input strobe. A fault-injection input flips one chosen copy, so the checking can be exercised in place.

Top module: `resilient_fmul`

## Requirements
- R1: With modeSel = 0 (full precision), the result fraction is the 48-bit product of the two 24-bit significands, normalised and truncated to 23 bits.
- R2: With modeSel = 1 (checking), each operand keeps fraction bits 22..13 plus bits 12..10 (the top 13 bits). The product is truncated to 13 fraction bits, and result bits 9..0 are zero.
- R3: With modeSel = 2 (repairing), each operand keeps the top 11 fraction bits (22..12). The product is truncated to 11 fraction bits, and result bits 11..0 are zero.
- R4: In checking mode, outErr is 1 exactly when the two copies differ. A flip injected into copy 1 raises outErr and leaves the result equal to the fault-free value.
- R5: In repairing mode, a flip injected into any single copy (0, 1 or 2) leaves the result equal to the fault-free value and raises outErr.
- R6: outErr is 0 in full-precision mode and whenever no copy is corrupted. In checking mode, a flip on copy 2 has no effect on either the result or outErr.
- R7: The result sign is the XOR of the operand signs. An operand whose exponent field (bits 30..23) is zero gives a zero result with that sign, in every mode.
- R8: A result exponent of 255 or more gives infinity (exponent field 255, fraction 0). A result exponent of 0 or less gives a signed zero.
- R9: outValid, outResult and outErr update one clock after a cycle with inValid high. Reset clears all three to zero.
- R10: modeSel = 3 behaves as full precision.
- R11: faultFlip bit k inverts the most significant bit of copy k's 28-bit product window (for copy 0, bit 47 of its full product).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| modeSel | input | 2 | 0 full precision, 1 checking, 2 repairing, 3 full precision |
| opA | input | 32 | First single-precision operand |
| opB | input | 32 | Second single-precision operand |
| faultFlip | input | 3 | Per-copy fault injection, bit k corrupts copy k |
| outValid | output | 1 | Result valid |
| outResult | output | 32 | Single-precision product |
| outErr | output | 1 | Copies disagreed for this result |

## Verification
The sweeps cover significand pairs whose product lands on either side of 2. A design that picked the wrong normalisation shift there would be off by a factor of two, or off by one in the exponent. Each mode is checked against its own truncation width, which catches leftover low fraction bits and the wrong number of kept bits. Single-copy flips are driven in both protected modes: a vote that let the faulty copy through would change the result, and a flag tied to the vote output would stay silent. A flip on the idle third copy in checking mode must change nothing. Exponent sums just past the top and bottom of the range, and zero operands of both signs, catch missing saturation or flush logic.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  localparam int FRAC_W = 23;
  localparam int EXP_W  = 8;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = 127;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_CHECK   = 2'd1,
    MODE_REPAIR  = 2'd2,
    MODE_FULL_B  = 2'd3
  } modeT;

  typedef struct packed {
    logic              capture;
    logic              checkOn;
    logic              repairOn;
    logic [FRAC_W-1:0] keepMask;
  } ctrlBusT;
endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
  import fmul_pkg::*;
#(
  parameter int CHECK_KEEP  = 13,
  parameter int REPAIR_KEEP = 11
) (
  input  logic    inValid,
  input  logic [1:0] modeSel,
  output ctrlBusT ctrlBus
);
  localparam logic [FRAC_W-1:0] ALL_ONES    = {FRAC_W{1'b1}};
  localparam logic [FRAC_W-1:0] CHECK_MASK  = ALL_ONES << (FRAC_W - CHECK_KEEP);
  localparam logic [FRAC_W-1:0] REPAIR_MASK = ALL_ONES << (FRAC_W - REPAIR_KEEP);

  always_comb begin
    ctrlBus.capture  = inValid;
    ctrlBus.checkOn  = 1'b0;
    ctrlBus.repairOn = 1'b0;
    ctrlBus.keepMask = ALL_ONES;
    unique case (modeT'(modeSel))
      MODE_CHECK: begin
        ctrlBus.checkOn  = 1'b1;
        ctrlBus.keepMask = CHECK_MASK;
      end
      MODE_REPAIR: begin
        ctrlBus.repairOn = 1'b1;
        ctrlBus.keepMask = REPAIR_MASK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fmul_dp.sv
module fmul_dp
  import fmul_pkg::*;
#(
  parameter int CHECK_KEEP = 13,
  parameter int COPIES     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlBusT           ctrlBus,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [COPIES-1:0] faultFlip,
  output logic              outValid,
  output logic [WORD_W-1:0] outResult,
  output logic              outErr
);
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int SMALL_W = CHECK_KEEP + 1;
  localparam int WIN_W   = 2 * SMALL_W;
  localparam int LOW_W   = PROD_W - WIN_W;
  localparam int DROP_W  = FRAC_W - CHECK_KEEP;
  localparam int SUM_W   = EXP_W + 2;
  localparam logic [SUM_W-1:0] OVF_LIM = SUM_W'((1 << EXP_W) - 1 + BIAS);
  localparam logic [SUM_W-1:0] UNF_LIM = SUM_W'(BIAS);

  logic              signA, signB, signR;
  logic [EXP_W-1:0]  expA, expB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic [SIG_W-1:0]  sigA, sigB;
  logic [PROD_W-1:0] mainProd;
  logic [WIN_W-1:0]  win [COPIES];
  logic [WIN_W-1:0]  voted, chosen;
  logic              mismatch;

  assign signA = opA[WORD_W-1];
  assign signB = opB[WORD_W-1];
  assign expA  = opA[FRAC_W +: EXP_W];
  assign expB  = opB[FRAC_W +: EXP_W];
  assign fracA = opA[FRAC_W-1:0] & ctrlBus.keepMask;
  assign fracB = opB[FRAC_W-1:0] & ctrlBus.keepMask;
  assign sigA  = {1'b1, fracA};
  assign sigB  = {1'b1, fracB};
  assign signR = signA ^ signB;

  // Copy 0: the full array, fed with masked significands in protected modes.
  always_comb begin
    mainProd = {{SIG_W{1'b0}}, sigA} * {{SIG_W{1'b0}}, sigB};
    mainProd[PROD_W-1] = mainProd[PROD_W-1] ^ faultFlip[0];
  end
  assign win[0] = mainProd[PROD_W-1 -: WIN_W];

  // Copies 1..COPIES-1: short arrays on the kept fraction slice.
  for (genvar c = 1; c < COPIES; c++) begin : gCopy
    logic [SMALL_W-1:0] smA, smB;
    logic [WIN_W-1:0]   smProd;
    assign smA = {1'b1, fracA[FRAC_W-1 -: CHECK_KEEP]};
    assign smB = {1'b1, fracB[FRAC_W-1 -: CHECK_KEEP]};
    always_comb begin
      smProd = {{SMALL_W{1'b0}}, smA} * {{SMALL_W{1'b0}}, smB};
      smProd[WIN_W-1] = smProd[WIN_W-1] ^ faultFlip[c];
    end
    assign win[c] = smProd;
  end

  // Compare or vote.
  always_comb begin
    voted    = (win[0] & win[1]) | (win[0] & win[2]) | (win[1] & win[2]);
    mismatch = 1'b0;
    chosen   = win[0];
    if (ctrlBus.repairOn) begin
      chosen   = voted;
      mismatch = (win[0] != voted) | (win[1] != voted) | (win[2] != voted);
    end else if (ctrlBus.checkOn) begin
      mismatch = (win[0] != win[1]);
    end
  end

  // Normalise, exponent, pack.
  logic [PROD_W-1:0] finalProd;
  logic              carryUp;
  logic [FRAC_W-1:0] fracR;
  logic [SUM_W-1:0]  expSum;
  logic [EXP_W-1:0]  expR;
  logic              anyZero;
  logic [WORD_W-1:0] packed_r;

  always_comb begin
    finalProd = {chosen, mainProd[LOW_W-1:0]};
    carryUp   = finalProd[PROD_W-1];
    fracR     = carryUp ? finalProd[PROD_W-2 -: FRAC_W] : finalProd[PROD_W-3 -: FRAC_W];
    fracR     = fracR & ctrlBus.keepMask;
    expSum    = SUM_W'(expA) + SUM_W'(expB) + SUM_W'(carryUp);
    expR      = EXP_W'(expSum - UNF_LIM);
    anyZero   = (expA == '0) || (expB == '0);
    if (anyZero || expSum <= UNF_LIM)
      packed_r = {signR, {(WORD_W-1){1'b0}}};
    else if (expSum >= OVF_LIM)
      packed_r = {signR, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      packed_r = {signR, expR, fracR};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outResult <= '0;
      outErr    <= 1'b0;
    end else begin
      outValid <= ctrlBus.capture;
      if (ctrlBus.capture) begin
        outResult <= packed_r;
        outErr    <= mismatch;
      end
    end
  end

  logic unusedDrop;
  assign unusedDrop = ^{DROP_W{1'b0}};
endmodule

// File: rtl/resilient_fmul.sv
module resilient_fmul
  import fmul_pkg::*;
#(
  parameter int CHECK_KEEP  = 13,
  parameter int REPAIR_KEEP = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [1:0]  modeSel,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [2:0]  faultFlip,
  output logic        outValid,
  output logic [31:0] outResult,
  output logic        outErr
);
  ctrlBusT ctrlBus;

  fmul_ctrl #(.CHECK_KEEP(CHECK_KEEP), .REPAIR_KEEP(REPAIR_KEEP)) u_ctrl (
    .inValid (inValid),
    .modeSel (modeSel),
    .ctrlBus (ctrlBus)
  );

  fmul_dp #(.CHECK_KEEP(CHECK_KEEP), .COPIES(3)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrlBus   (ctrlBus),
    .opA       (opA),
    .opB       (opB),
    .faultFlip (faultFlip),
    .outValid  (outValid),
    .outResult (outResult),
    .outErr    (outErr)
  );
endmodule

// File: rtl/fmul_checker.sv
module fmul_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic [1:0]  modeSel,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [2:0]  faultFlip,
  input logic        outValid,
  input logic [31:0] outResult,
  input logic        outErr
);
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  p_sign_xor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outResult[31] == $past(opA[31] ^ opB[31]));
  p_zero_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opA[30:23] == 8'd0) |=> outResult[30:0] == 31'd0);
  p_check_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && modeSel == 2'd1) |=> outResult[9:0] == 10'd0);
  p_repair_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && modeSel == 2'd2) |=> outResult[11:0] == 12'd0);
  p_full_noerr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && modeSel[0] == modeSel[1]) |=> !outErr);
  p_clean_noerr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && faultFlip == 3'd0) |=> !outErr);
endmodule

bind resilient_fmul fmul_checker chk_i (.*);

// File: tb/resilient_fmul_tb_top.sv
module resilient_fmul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  faultFlip = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic        outErr;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] rngState = 32'h1234_5678;

  always #10 clk = ~clk;

  resilient_fmul dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .modeSel(modeSel),
    .opA(opA), .opB(opB), .faultFlip(faultFlip),
    .outValid(outValid), .outResult(outResult), .outErr(outErr)
  );

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] m, input logic [2:0] inj);
    int keep, e;
    longint ma, mb, p, fr, top;
    logic s, err;
    logic [31:0] r;
    keep = (m == 2'd1) ? 13 : (m == 2'd2) ? 11 : 23;
    ma = (longint'(1) << keep) | longint'(a[22:0] >> (23 - keep));
    mb = (longint'(1) << keep) | longint'(b[22:0] >> (23 - keep));
    p  = ma * mb;
    top = (p >> (2 * keep + 1)) & 1;
    fr = (top != 0) ? (p >> (keep + 1)) : (p >> keep);
    fr = fr & ((longint'(1) << keep) - 1);
    e  = int'(a[30:23]) + int'(b[30:23]) - 127 + int'(top);
    s  = a[31] ^ b[31];
    if (a[30:23] == 8'd0 || b[30:23] == 8'd0 || e <= 0) r = {s, 31'd0};
    else if (e >= 255) r = {s, 8'hFF, 23'd0};
    else r = {s, e[7:0], 23'(fr << (23 - keep))};
    err = (m == 2'd1) ? (inj[0] | inj[1]) : (m == 2'd2) ? (|inj) : 1'b0;
    return {err, r};
  endfunction

  task automatic check(input string req, input logic [31:0] gotV, input logic [31:0] expV);
    nChecks++;
    if (gotV !== expV) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, gotV, expV);
    end
  endtask

  task automatic runOp(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] m, input logic [2:0] inj);
    logic [32:0] exp_v;
    exp_v = model(a, b, m, inj);
    opA = a; opB = b; modeSel = m; faultFlip = inj; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; faultFlip = '0;
    check(req, {31'd0, outValid}, 32'd1);
    check(req, outResult, exp_v[31:0]);
    check(req, {31'd0, outErr}, {31'd0, exp_v[32]});
  endtask

  function automatic logic [31:0] nextRand();
    logic [31:0] x;
    x = rngState;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    rngState = x;
    return x;
  endfunction

  function automatic logic [31:0] mkOp(input logic [31:0] rv);
    logic [7:0] e;
    e = 8'(70 + (rv[30:23] % 110));
    return {rv[31], e, rv[22:0]};
  endfunction

  initial begin : watchdog
    #3000000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    @(negedge clk); @(negedge clk);
    // R9: reset state
    check("R9 reset", {outErr, outValid, 30'd0}, 32'd0);
    check("R9 reset", outResult, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle", {31'd0, outValid}, 32'd0);

    // R1 normalisation boundaries
    runOp("R1 one", 32'h3F80_0000, 32'h3F80_0000, 2'd0, 3'd0);
    runOp("R1 carry", 32'h3FC0_0000, 32'h3FC0_0000, 2'd0, 3'd0);
    runOp("R1 allones", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 2'd0, 3'd0);
    runOp("R2 allones", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 2'd1, 3'd0);
    runOp("R3 allones", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 2'd2, 3'd0);
    // R7 zeros and signs
    for (int m = 0; m < 3; m++) begin
      runOp("R7 zeroA", 32'h8000_0000, 32'h4040_0000, 2'(m), 3'd0);
      runOp("R7 zeroB", 32'hC120_0000, 32'h0012_3456, 2'(m), 3'd0);
    end
    // R8 saturation and flush
    runOp("R8 ovf", 32'h7F00_0000, 32'h4000_0000, 2'd0, 3'd0);
    runOp("R8 ovf", 32'hE000_0000, 32'h6000_0000, 2'd2, 3'd0);
    runOp("R8 edge", 32'h7EFF_FFFF, 32'h3F80_0000, 2'd0, 3'd0);
    runOp("R8 unf", 32'h0080_0000, 32'h3F00_0000, 2'd0, 3'd0);
    runOp("R8 unf", 32'h8A00_0000, 32'h1000_0000, 2'd1, 3'd0);
    runOp("R8 edge", 32'h0080_0000, 32'h3F80_0000, 2'd0, 3'd0);

    // Sweeps per mode, with fault injection in protected modes
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = mkOp(nextRand());
      b = mkOp(nextRand());
      runOp("R1 sweep",  a, b, 2'd0, 3'd0);
      runOp("R10 sweep", a, b, 2'd3, 3'd0);
      runOp("R2 sweep",  a, b, 2'd1, 3'd0);
      runOp("R3 sweep",  a, b, 2'd2, 3'd0);
      runOp("R4 R11 flip1", a, b, 2'd1, 3'b010);
      runOp("R6 flip2 idle", a, b, 2'd1, 3'b100);
      runOp("R5 R11 flip", a, b, 2'd2, 3'(1 << (i % 3)));
    end

    // R9: back-to-back then idle
    runOp("R9 b2b", 32'h4000_0000, 32'h4000_0000, 2'd0, 3'd0);
    @(negedge clk);
    check("R9 drop", {31'd0, outValid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule